// File: doc/BRIEF.md
# Converter Power-State Detector

This block works out the power state of a sampling converter using only its two control pins: the convert-start pin and the serial clock pin. Both pins pass through a synchronizer and a rising-edge detector in the system clock domain. A saturating counter tracks how many convert rising edges have arrived since the last serial clock rising edge. A small state machine turns that count into one of three states: active, nap or sleep. Any serial clock rising edge wakes the converter.

The block also drives a reference-ready flag. It tells the surrounding model or host when conversions are accurate again. Nap leaves the reference powered, so the flag stays high. Sleep powers the reference down. After a wake from sleep, a settle timer with a parameterised length must run out before the flag goes high again. The block does no actual power switching or analog settling.

Top module: `pwr_mode_detect`

## Requirements
- R1: After a synchronous active-low reset, the block is active with `ref_ready` high and no convert edges counted.
- R2: A second convert rising edge with no serial clock rising edge since the first moves the block from active to nap.
- R3: A fourth convert rising edge with no serial clock rising edge between the edges enters sleep. This applies from active and from nap. A block in nap goes straight to sleep without passing through active.
- R4: The edge counter saturates at four, so further convert edges keep the block in sleep.
- R5: A serial clock rising edge returns the block to active from nap or from sleep, and clears the edge count. A single convert edge after it leaves the block active.
- R6: Entering nap and waking from nap leave `ref_ready` high.
- R7: `ref_ready` goes low on the same clock edge on which the block enters sleep, and stays low for as long as the block is asleep.
- R8: After a wake from sleep, `ref_ready` rises exactly SETTLE_CYCLES clock cycles after the clock edge that registers the wake. If the block goes back to sleep before that, the wait starts again from the next wake.
- R9: Exactly one of `is_active`, `is_nap` and `is_sleep` is high at all times.
- R10: Falling edges on either pin have no effect. A pin rising edge changes the outputs SYNC_STAGES+1 clock edges after the pin is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_pin | input | 1 | Convert-start pin, asynchronous |
| sck_pin | input | 1 | Serial clock pin, asynchronous |
| is_active | output | 1 | Converter is in the active state |
| is_nap | output | 1 | Converter is in nap |
| is_sleep | output | 1 | Converter is in sleep |
| ref_ready | output | 1 | Reference settled, conversions accurate |

## Verification
The table-driven pass uses several pin sequences. Runs of two, three, four and six convert pulses show where the nap and sleep thresholds sit and that the counter saturates. A serial clock pulse placed inside a run shows that the count is cleared and not merely paused. Directed tests measure how many cycles a wake takes to appear at the outputs and how long the settle wait lasts. Other directed tests send the block back to sleep partway through settling, and wake it from nap, to separate a reference that was powered down from one that stayed on.

// File: rtl/pmd_pkg.sv
// Shared types for the converter power-state detector.
// Assumes nothing beyond a single system clock domain.
package pmd_pkg;
    typedef enum logic [1:0] {
        PM_ACTIVE = 2'd0,
        PM_NAP    = 2'd1,
        PM_SLEEP  = 2'd2
    } pm_state_e;
endpackage

// File: rtl/pmd_rise_det.sv
// Synchronizes an asynchronous pin and flags its rising edges.
// Assumes STAGES >= 2; the output pulse lasts one clock cycle.
module pmd_rise_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [STAGES:0] pipe;

    // Shift the pin through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], pin};
    end

    // Rising edge: newest synchronized sample high, previous one low.
    always_comb rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/pmd_edge_counter.sv
// Counts convert rising edges since the last serial clock rising edge.
// Assumes a serial clock edge wins a tie; a coincident convert edge counts as one.
module pmd_edge_counter #(
    parameter int SAT_COUNT = 4,
    localparam int CW = $clog2(SAT_COUNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_rise,
    input  logic          sck_rise,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] SAT = CW'(SAT_COUNT);

    // Clear on a clock edge, otherwise count convert edges up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)                        count <= '0;
        else if (sck_rise)                 count <= conv_rise ? CW'(1) : '0;
        else if (conv_rise && count != SAT) count <= count + CW'(1);
    end
endmodule

// File: rtl/pmd_state_fsm.sv
// Power-state machine fed by edge pulses and the current edge count.
// Assumes count is the registered value before this cycle's edges.
module pmd_state_fsm #(
    parameter int NAP_EDGES   = 2,
    parameter int SLEEP_EDGES = 4,
    localparam int CW = $clog2(SLEEP_EDGES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               conv_rise,
    input  logic               sck_rise,
    input  logic [CW-1:0]      count,
    output pmd_pkg::pm_state_e state,
    output logic               sleep_entry,
    output logic               wake_from_sleep
);
    import pmd_pkg::*;

    localparam logic [CW-1:0] NAP_PRE   = CW'(NAP_EDGES - 1);
    localparam logic [CW-1:0] SLEEP_PRE = CW'(SLEEP_EDGES - 1);

    pm_state_e state_nx;

    // Event decode for the settle timer.
    always_comb begin
        sleep_entry     = conv_rise && !sck_rise && count >= SLEEP_PRE && state != PM_SLEEP;
        wake_from_sleep = sck_rise && state == PM_SLEEP;
    end

    // Next-state choice: a wake beats everything, then sleep, then nap.
    always_comb begin
        state_nx = state;
        if (sck_rise)
            state_nx = PM_ACTIVE;
        else if (conv_rise && count >= SLEEP_PRE)
            state_nx = PM_SLEEP;
        else if (conv_rise && count >= NAP_PRE && state == PM_ACTIVE)
            state_nx = PM_NAP;
    end

    // State register, active after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PM_ACTIVE;
        else        state <= state_nx;
    end
endmodule

// File: rtl/pmd_settle_timer.sv
// Models reference settling: ready drops on sleep entry and rises a fixed
// number of cycles after the wake edge. Assumes SETTLE_CYCLES >= 1.
module pmd_settle_timer #(
    parameter int SETTLE_CYCLES = 500000,
    localparam int TW = $clog2(SETTLE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_entry,
    input  logic wake_from_sleep,
    output logic ready
);
    localparam logic [TW-1:0] LAST = TW'(SETTLE_CYCLES - 1);

    logic          busy;
    logic [TW-1:0] elapsed;

    // Drop on sleep entry, start on wake, raise ready when the wait ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready   <= 1'b1;
            busy    <= 1'b0;
            elapsed <= '0;
        end else if (sleep_entry) begin
            ready   <= 1'b0;
            busy    <= 1'b0;
            elapsed <= '0;
        end else if (wake_from_sleep) begin
            busy    <= 1'b1;
            elapsed <= '0;
        end else if (busy) begin
            if (elapsed == LAST) begin
                busy  <= 1'b0;
                ready <= 1'b1;
            end else begin
                elapsed <= elapsed + TW'(1);
            end
        end
    end
endmodule

// File: rtl/pwr_mode_detect.sv
// Top level: derives the converter power state from its control pins.
// Assumes both pins are asynchronous to clk and held for more than
// SYNC_STAGES+1 cycles per level.
module pwr_mode_detect #(
    parameter int SYNC_STAGES   = 2,
    parameter int NAP_EDGES     = 2,
    parameter int SLEEP_EDGES   = 4,
    parameter int SETTLE_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_pin,
    input  logic sck_pin,
    output logic is_active,
    output logic is_nap,
    output logic is_sleep,
    output logic ref_ready
);
    import pmd_pkg::*;

    localparam int CW = $clog2(SLEEP_EDGES + 1);

    logic          conv_rise;
    logic          sck_rise;
    logic [CW-1:0] edge_count;
    pm_state_e     state;
    logic          sleep_entry;
    logic          wake_from_sleep;

    pmd_rise_det #(.STAGES(SYNC_STAGES)) u_conv_det (
        .clk(clk), .rst_n(rst_n), .pin(conv_pin), .rise(conv_rise)
    );

    pmd_rise_det #(.STAGES(SYNC_STAGES)) u_sck_det (
        .clk(clk), .rst_n(rst_n), .pin(sck_pin), .rise(sck_rise)
    );

    pmd_edge_counter #(.SAT_COUNT(SLEEP_EDGES)) u_count (
        .clk(clk), .rst_n(rst_n), .conv_rise(conv_rise),
        .sck_rise(sck_rise), .count(edge_count)
    );

    pmd_state_fsm #(.NAP_EDGES(NAP_EDGES), .SLEEP_EDGES(SLEEP_EDGES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .conv_rise(conv_rise), .sck_rise(sck_rise),
        .count(edge_count), .state(state), .sleep_entry(sleep_entry),
        .wake_from_sleep(wake_from_sleep)
    );

    pmd_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk(clk), .rst_n(rst_n), .sleep_entry(sleep_entry),
        .wake_from_sleep(wake_from_sleep), .ready(ref_ready)
    );

    // Status decode from the registered state.
    always_comb begin
        is_active = (state == PM_ACTIVE);
        is_nap    = (state == PM_NAP);
        is_sleep  = (state == PM_SLEEP);
    end
endmodule

// File: rtl/pmd_checker.sv
// Property checks for pwr_mode_detect, attached by bind.
// Assumes the detected serial clock edge pulse is visible from the top.
module pmd_checker #(
    parameter int SETTLE_CYCLES = 500000,
    localparam int WW = $clog2(SETTLE_CYCLES + 2)
) (
    input logic clk,
    input logic rst_n,
    input logic sck_rise,
    input logic is_active,
    input logic is_nap,
    input logic is_sleep,
    input logic ref_ready
);
    localparam logic [WW-1:0] DONE = WW'(SETTLE_CYCLES + 1);

    logic [WW-1:0] win;

    // Cycles since the last wake from sleep, capped at DONE, cleared while asleep.
    always_ff @(posedge clk) begin
        if (!rst_n)                       win <= '0;
        else if (sck_rise && is_sleep)    win <= WW'(1);
        else if (is_sleep)                win <= '0;
        else if (win != '0 && win != DONE) win <= win + WW'(1);
    end

    a_r9_one_state: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({is_active, is_nap, is_sleep}) == 1);

    a_r5_wake: assert property (@(posedge clk) disable iff (!rst_n)
        sck_rise |=> is_active);

    a_r4_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sleep && !sck_rise) |=> is_sleep);

    a_r2_nap_from_active: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_nap) |-> $past(is_active));

    a_r7_sleep_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        is_sleep |-> !ref_ready);

    a_r6_nap_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (is_nap && $past(ref_ready)) |-> ref_ready);

    a_r8_settle_time: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_ready) |-> (win == DONE));
endmodule

bind pwr_mode_detect pmd_checker #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .is_active(is_active),
    .is_nap(is_nap), .is_sleep(is_sleep), .ref_ready(ref_ready)
);

// File: tb/tb_pwr_mode_detect.sv
module tb_pwr_mode_detect;
    localparam int SETTLE = 40;
    localparam int SYNC   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_pin = 1'b0;
    logic sck_pin = 1'b0;
    logic is_active, is_nap, is_sleep, ref_ready;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pwr_mode_detect #(.SYNC_STAGES(SYNC), .SETTLE_CYCLES(SETTLE)) dut (
        .clk(clk), .rst_n(rst_n), .conv_pin(conv_pin), .sck_pin(sck_pin),
        .is_active(is_active), .is_nap(is_nap), .is_sleep(is_sleep),
        .ref_ready(ref_ready)
    );

    // Expected status as {active, nap, sleep, ready}
    localparam logic [3:0] A1 = 4'b1001, A0 = 4'b1000, N1 = 4'b0101, S0 = 4'b0010;

    // Vector: [4] op (1 = serial clock pulse, 0 = convert pulse), [3:0] expected status
    localparam logic [4:0] VEC [10] = '{
        {1'b0, A1}, {1'b0, N1}, {1'b1, A1}, {1'b0, A1}, {1'b0, N1},
        {1'b0, N1}, {1'b0, S0}, {1'b0, S0}, {1'b0, S0}, {1'b1, A0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] status();
        return {is_active, is_nap, is_sleep, ref_ready};
    endfunction

    task automatic pulse(input logic use_sck);
        @(negedge clk);
        if (use_sck) sck_pin = 1'b1; else conv_pin = 1'b1;
        repeat (4) @(negedge clk);
        if (use_sck) sck_pin = 1'b0; else conv_pin = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic conv_n(input int n);
        for (int i = 0; i < n; i++) pulse(1'b0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int k;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset state", 32'(status()), 32'(A1));

        // Table pass: R2 nap, R3 sleep from nap, R4 saturation, R5 wake/clear, R7 ready drop
        for (int i = 0; i < 10; i++) begin
            pulse(VEC[i][4]);
            chk($sformatf("R2/R3/R4/R5/R7 vector %0d", i), 32'(status()), 32'(VEC[i][3:0]));
        end

        // R8: settle completes after waiting
        repeat (45) @(negedge clk);
        chk("R8 ready after settle", 32'(status()), 32'(A1));

        // R3 from active straight to sleep, then R10 latency and R8 exact length
        conv_n(4);
        chk("R3 four edges sleep", 32'(status()), 32'(S0));
        @(negedge clk);
        sck_pin = 1'b1;
        k = 0;
        while (!is_active && k < 10) begin
            @(negedge clk);
            k++;
        end
        chk("R10 wake latency", 32'(k), 32'(SYNC + 1));
        sck_pin = 1'b0;
        n = 0;
        while (!ref_ready && n < 200) begin
            n++;
            @(negedge clk);
        end
        chk("R8 settle length", 32'(n), 32'(SETTLE));

        // R6: nap keeps the reference ready across entry and wake
        conv_n(2);
        chk("R6 nap keeps ready", 32'(status()), 32'(N1));
        pulse(1'b1);
        chk("R6 wake from nap ready", 32'(status()), 32'(A1));

        // R5: a serial clock edge between convert edges clears the count
        pulse(1'b0);
        pulse(1'b1);
        pulse(1'b0);
        chk("R5 count cleared", 32'(status()), 32'(A1));

        // R8: going back to sleep during settling restarts the wait
        conv_n(4);
        pulse(1'b1);
        chk("R8 settling after wake", 32'(status()), 32'(A0));
        conv_n(4);
        chk("R7 resleep mid settle", 32'(status()), 32'(S0));
        repeat (60) @(negedge clk);
        chk("R8 no settling while asleep", 32'(status()), 32'(S0));
        pulse(1'b1);
        repeat (25) @(negedge clk);
        chk("R8 wait restarted", 32'(status()), 32'(A0));
        repeat (20) @(negedge clk);
        chk("R8 ready after restart", 32'(status()), 32'(A1));

        // R10: a falling edge alone does nothing
        @(negedge clk);
        conv_pin = 1'b1;
        repeat (6) @(negedge clk);
        chk("R10 first rise counted", 32'(status()), 32'(A1));
        conv_pin = 1'b0;
        repeat (6) @(negedge clk);
        chk("R10 falling edge ignored", 32'(status()), 32'(A1));
        pulse(1'b0);
        chk("R2 second rise nap", 32'(status()), 32'(N1));
        pulse(1'b1);

        // R1: reset from sleep restores active and ready
        conv_n(5);
        chk("R4 five edges sleep", 32'(status()), 32'(S0));
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset from sleep", 32'(status()), 32'(A1));
        pulse(1'b0);
        chk("R1 count cleared by reset", 32'(status()), 32'(A1));

        finish_run();
    end
endmodule